// File: doc/BRIEF.md
# Seconds Counter with Dual Alarms

This core keeps wall-clock time as a 32-bit count of seconds. A prescaler consumes a 32768 Hz tick enable and produces a one-second boundary pulse and a half-second pulse. Two alarm compare registers watch the count. When an alarm matches, an event bit is latched in a status register. Software clears that bit by writing one to it.

Each alarm has its own interrupt-configuration register. It combines an alarm interrupt enable with a periodic interrupt, and the periodic interrupt runs at either 1 Hz or 2 Hz. Each alarm drives its own level interrupt, and a combined line ORs the two. A setup register carries a non-zero marker byte out of reset. Software clears that byte to show the clock has been initialized. A trim register stores a calibration word that other logic uses.

Writes from the register bus are not applied at once. The core accepts a write into a hold-off gate, keeps it there for a programmable window (5 µs at 100 MHz by default), and only then commits it. During that window the core reports busy and holds back any further write. Reads are served every cycle with one cycle of latency.

Top module: `rtc_core`

## Requirements
- R1: After reset: status, seconds, both configuration registers, both alarm values and the trim register read 0; the setup register reads INIT_MARK (default 0xA5) with its ready bit 8 clear; irq_alarm, irq_any and busy are low.
- R2: The core accepts a write in a cycle where wr_en is high and busy is low. Busy then stays high for exactly HOLD_CYCLES cycles. The target register keeps its old value until busy falls. Status bit 31 reads back busy.
- R3: While busy is high, wr_ready is low and no new write is accepted. A held write is accepted in the first cycle after busy falls, and both writes land.
- R4: The seconds count advances by one for every PRESCALE clock cycles in which tick_32k is high. Cycles with tick_32k low do not advance the prescaler or the count.
- R5: Writing the seconds register (word 3) replaces the count and restarts the prescaler, so the next increment comes PRESCALE ticks later. The count wraps from 0xFFFFFFFF to 0.
- R6: When the count steps onto the value of alarm A (word 4) or alarm B (word 5), status bit 0 (alarm A) or bit 1 (alarm B) is set, whatever the enables are. Writing the count directly to an alarm value does not set the bit.
- R7: Status (word 0) bits [1:0] are write-one-to-clear. A 0 written to a bit leaves it unchanged. A set bit stays set until it is cleared.
- R8: In configuration words 1 (alarm A) and 2 (alarm B), bit 0 is the alarm enable. irq_alarm[i] is high while status bit i and alarm enable i are both set.
- R9: In the configuration words, bit 1 enables a periodic interrupt and bit 2 picks its rate: 1 gives 1 Hz, a one-cycle pulse per PRESCALE ticks; 0 gives 2 Hz, two pulses per PRESCALE ticks.
- R10: irq_any is high exactly when either irq_alarm bit is high.
- R11: Setup register (word 7) bits [7:0] are read/write. Bit 8 reads 1 only while those bits are zero, which marks the clock as initialized.
- R12: The trim register (word 6) stores bits [15:0] of a write and reads them back, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | 32768 Hz tick enable, one clock wide |
| wr_en | input | 1 | Write request, held until accepted |
| rd_en | input | 1 | Read request |
| bus_word | input | 3 | Register word index |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | Write accepted this cycle when high |
| busy | output | 1 | A write is pending in the hold-off window |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | rd_data holds a fresh result |
| irq_alarm | output | 2 | Per-alarm interrupt, bit 0 for alarm A |
| irq_any | output | 1 | OR of both alarm interrupts |

## Verification
A wrong seconds count or prescaler phase shows up as a misplaced alarm status bit on the first matching boundary, and on the next read of word 3. A hold-off counter that is off by one changes how long busy stays high and the cycle in which a stalled write is accepted, so it is visible within HOLD_CYCLES cycles. A status bit that fails to stay set, or clears on a 0 write, shows up at irq_alarm in the cycle after the offending commit. A wrong rate select shows up as the wrong number of interrupt pulses across two seconds of ticks.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

  localparam int NUM_ALARMS = 2;

  typedef enum logic [2:0] {
    RG_STATUS  = 3'd0,
    RG_CFG_A   = 3'd1,
    RG_CFG_B   = 3'd2,
    RG_SECONDS = 3'd3,
    RG_ALARM_A = 3'd4,
    RG_ALARM_B = 3'd5,
    RG_TRIM    = 3'd6,
    RG_SETUP   = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic sel_1hz;
    logic per_en;
    logic alarm_en;
  } irq_cfg_t;

endpackage

// File: rtl/rtc_write_gate.sv
module rtc_write_gate #(
  parameter int HOLD_CYCLES = 500,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              busy,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] hold_cnt;
  logic             busy_q;

  assign busy     = busy_q;
  assign wr_ready = !busy_q;
  assign commit   = busy_q && (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      hold_cnt    <= '0;
      commit_addr <= '0;
      commit_data <= '0;
    end else if (!busy_q && wr_en) begin
      busy_q      <= 1'b1;
      hold_cnt    <= LOAD;
      commit_addr <= wr_addr;
      commit_data <= wr_data;
    end else if (busy_q) begin
      if (hold_cnt == '0) busy_q <= 1'b0;
      else                hold_cnt <= hold_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  output logic pulse_1hz,
  output logic pulse_2hz
);
  localparam int CNT_W = $clog2(PRESCALE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(PRESCALE / 2 - 1);

  logic [CNT_W-1:0] cnt;

  assign pulse_1hz = tick && !restart && (cnt == LAST);
  assign pulse_2hz = tick && !restart && ((cnt == LAST) || (cnt == MID));

  always_ff @(posedge clk) begin
    if (rst || restart)      cnt <= '0;
    else if (tick) begin
      if (cnt == LAST)       cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_pulse,
  input  logic [DATA_W-1:0] sec_next,
  input  logic [DATA_W-1:0] match_val,
  input  logic              clear,
  input  irq_cfg_t          cfg,
  input  logic              pulse_1hz,
  input  logic              pulse_2hz,
  output logic              event_q,
  output logic              irq_next,
  output logic              irq_q
);
  logic hit, event_n, periodic;

  assign hit      = sec_pulse && (sec_next == match_val);
  assign event_n  = (event_q && !clear) || hit;
  assign periodic = cfg.sel_1hz ? pulse_1hz : pulse_2hz;
  assign irq_next = (event_n && cfg.alarm_en) || (periodic && cfg.per_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      event_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      event_q <= event_n;
      irq_q   <= irq_next;
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_core_pkg::*;
#(
  parameter int          PRESCALE    = 32768,
  parameter int          HOLD_CYCLES = 500,
  parameter int          TRIM_W      = 16,
  parameter int          MARK_W      = 8,
  parameter logic [7:0]  INIT_MARK   = 8'hA5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_32k,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  bus_word,
  input  logic [31:0] wr_data,
  output logic        wr_ready,
  output logic        busy,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic [1:0]  irq_alarm,
  output logic        irq_any
);
  localparam int DATA_W = 32;
  localparam int CFG_W  = $bits(irq_cfg_t);

  logic                  commit;
  logic [2:0]            commit_addr;
  logic [DATA_W-1:0]     commit_data;
  logic                  sec_restart, sec_pulse, pulse_2hz;
  logic [DATA_W-1:0]     seconds_q, sec_next;
  logic [TRIM_W-1:0]     trim_q;
  logic [MARK_W-1:0]     setup_q;
  logic [NUM_ALARMS-1:0] status_q, stat_clr, irq_next;
  irq_cfg_t              cfg_q   [NUM_ALARMS];
  logic [DATA_W-1:0]     alarm_q [NUM_ALARMS];
  logic                  irq_any_q;

  rtc_write_gate #(.HOLD_CYCLES(HOLD_CYCLES), .ADDR_W(3), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(bus_word), .wr_data(wr_data),
    .wr_ready(wr_ready), .busy(busy), .commit(commit),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  assign sec_restart = commit && (commit_addr == RG_SECONDS);

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst(rst), .tick(tick_32k), .restart(sec_restart),
    .pulse_1hz(sec_pulse), .pulse_2hz(pulse_2hz)
  );

  assign sec_next = seconds_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)              seconds_q <= '0;
    else if (sec_restart) seconds_q <= commit_data;
    else if (sec_pulse)   seconds_q <= sec_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_q  <= '0;
      setup_q <= INIT_MARK[MARK_W-1:0];
    end else if (commit) begin
      if (commit_addr == RG_TRIM)  trim_q  <= commit_data[TRIM_W-1:0];
      if (commit_addr == RG_SETUP) setup_q <= commit_data[MARK_W-1:0];
    end
  end

  assign stat_clr = (commit && commit_addr == RG_STATUS) ? commit_data[NUM_ALARMS-1:0] : '0;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    localparam logic [2:0] CFG_SEL   = 3'(RG_CFG_A + i);
    localparam logic [2:0] ALARM_SEL = 3'(RG_ALARM_A + i);

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i]   <= '0;
        alarm_q[i] <= '0;
      end else if (commit) begin
        if (commit_addr == CFG_SEL)   cfg_q[i]   <= irq_cfg_t'(commit_data[CFG_W-1:0]);
        if (commit_addr == ALARM_SEL) alarm_q[i] <= commit_data;
      end
    end

    rtc_alarm_unit #(.DATA_W(DATA_W)) u_unit (
      .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .sec_next(sec_next),
      .match_val(alarm_q[i]), .clear(stat_clr[i]), .cfg(cfg_q[i]),
      .pulse_1hz(sec_pulse), .pulse_2hz(pulse_2hz),
      .event_q(status_q[i]), .irq_next(irq_next[i]), .irq_q(irq_alarm[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_any_q <= 1'b0;
    else     irq_any_q <= |irq_next;
  end
  assign irq_any = irq_any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        unique case (reg_sel_e'(bus_word))
          RG_STATUS:  rd_data <= {busy, {(DATA_W-1-NUM_ALARMS){1'b0}}, status_q};
          RG_CFG_A:   rd_data <= {{(DATA_W-CFG_W){1'b0}}, cfg_q[0]};
          RG_CFG_B:   rd_data <= {{(DATA_W-CFG_W){1'b0}}, cfg_q[1]};
          RG_SECONDS: rd_data <= seconds_q;
          RG_ALARM_A: rd_data <= alarm_q[0];
          RG_ALARM_B: rd_data <= alarm_q[1];
          RG_TRIM:    rd_data <= {{(DATA_W-TRIM_W){1'b0}}, trim_q};
          RG_SETUP:   rd_data <= {{(DATA_W-MARK_W-1){1'b0}}, (setup_q == '0), setup_q};
          default:    rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        busy,
  input logic        commit,
  input logic        sec_pulse,
  input logic        sec_restart,
  input logic [31:0] seconds_q,
  input logic [1:0]  status_q,
  input logic [1:0]  stat_clr,
  input logic [1:0]  irq_alarm,
  input logic        irq_any
);
  assert_busy_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en));

  assert_stall_keeps_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy && !commit) |=> busy);

  assert_seconds_step_R4: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !sec_restart) |=> (seconds_q == $past(seconds_q) + 32'd1));

  assert_seconds_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!sec_pulse && !sec_restart) |=> $stable(seconds_q));

  assert_status_a_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && !stat_clr[0]) |=> status_q[0]);

  assert_status_b_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (status_q[1] && !stat_clr[1]) |=> status_q[1]);

  assert_irq_any_R10: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_alarm[0] || irq_alarm[1]));
endmodule

bind rtc_core rtc_core_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy), .commit(commit),
  .sec_pulse(sec_pulse), .sec_restart(sec_restart), .seconds_q(seconds_q),
  .status_q(status_q), .stat_clr(stat_clr), .irq_alarm(irq_alarm), .irq_any(irq_any)
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  localparam int P = 8;
  localparam int H = 6;

  logic        clk = 1'b0, rst = 1'b1, tick_32k = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, busy, rd_valid, irq_any;
  logic [31:0] rd_data;
  logic [1:0]  irq_alarm;

  int errors = 0, checks = 0;
  int stall_cycles;
  int cnt_a = 0, cnt_b = 0, cnt_any = 0;
  logic count_en = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  rtc_core #(.PRESCALE(P), .HOLD_CYCLES(H)) u_dut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .wr_en(wr_en), .rd_en(rd_en),
    .bus_word(bus_word), .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_alarm(irq_alarm), .irq_any(irq_any)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads as results appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check(1, 0, "unexpected rd_valid");
      else check(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
    if (count_en) begin
      if (irq_alarm[0]) cnt_a++;
      if (irq_alarm[1]) cnt_b++;
      if (irq_any)      cnt_any++;
    end
  end

  task automatic rd(input logic [2:0] w, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; bus_word = w;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; bus_word = w; wr_data = d;
    stall_cycles = 0;
    while (!wr_ready) begin stall_cycles++; @(negedge clk); end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    bus_write(w, d);
    wait_idle();
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_32k = 1'b1;
    repeat (n) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic count_window(input int n);
    cnt_a = 0; cnt_b = 0; cnt_any = 0;
    @(negedge clk); count_en = 1'b1;
    ticks(n);
    @(negedge clk); @(negedge clk);
    count_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({29'b0, busy, irq_alarm}, 0, "R1 busy/irq after reset");
    check(irq_any, 0, "R1 irq_any after reset");
    rd(3'd0, 0, "R1 status");
    rd(3'd3, 0, "R1 seconds");
    rd(3'd1, 0, "R1 cfg A");
    rd(3'd4, 0, "R1 alarm A");
    rd(3'd6, 0, "R1 trim");
    rd(3'd7, 32'h0000_00A5, "R1 R11 setup marker");

    // R2 hold-off length
    bus_write(3'd5, 32'h55);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n, H, "R2 busy duration");
    // R2 old value visible during hold-off
    bus_write(3'd3, 32'd50);
    rd(3'd3, 0, "R2 seconds unchanged while pending");
    rd(3'd0, 32'h8000_0000, "R2 busy in status bit 31");
    wait_idle();
    rd(3'd3, 32'd50, "R2 seconds after commit");

    // R3 back-to-back writes
    bus_write(3'd4, 32'd7);
    bus_write(3'd5, 32'd9);
    check(stall_cycles, H - 1, "R3 second write stalled");
    wait_idle();
    rd(3'd4, 32'd7, "R3 first write landed");
    rd(3'd5, 32'd9, "R3 second write landed");

    // R11 / R12
    wr(3'd7, 0);
    rd(3'd7, 32'h0000_0100, "R11 initialized flag");
    wr(3'd7, 32'h3C);
    rd(3'd7, 32'h0000_003C, "R11 marker rewritten");
    wr(3'd6, 32'hDEAD_BEEF);
    rd(3'd6, 32'h0000_BEEF, "R12 trim readback");

    // R4 / R5 counting
    wr(3'd4, 32'hFFFF_0000);
    wr(3'd5, 32'hFFFF_0000);
    wr(3'd3, 32'd100);
    ticks(3 * P);
    rd(3'd3, 32'd103, "R4 three seconds");
    repeat (20) @(negedge clk);
    rd(3'd3, 32'd103, "R4 no tick no advance");
    ticks(P - 1);
    rd(3'd3, 32'd103, "R4 one tick short");
    ticks(1);
    rd(3'd3, 32'd104, "R4 boundary tick");

    // R6 / R8 alarms
    wr(3'd3, 32'd200);
    wr(3'd4, 32'd203);
    wr(3'd1, 32'h1);
    wr(3'd5, 32'd202);
    ticks(2 * P);
    check({30'b0, irq_alarm}, 0, "R6 R8 alarm B latched without irq");
    rd(3'd0, 32'h2, "R6 status B set regardless of enable");
    ticks(P - 1);
    check(irq_alarm[0], 0, "R8 alarm A not yet");
    ticks(1);
    check(irq_alarm[0], 1, "R8 alarm A irq");
    check(irq_any, 1, "R10 irq_any follows alarm A");
    rd(3'd0, 32'h3, "R6 both status bits");

    // R7 write-one-to-clear
    wr(3'd0, 0);
    rd(3'd0, 32'h3, "R7 zero write no effect");
    check(irq_alarm[0], 1, "R7 irq held after zero write");
    wr(3'd0, 32'h1);
    rd(3'd0, 32'h2, "R7 clear bit 0");
    check({irq_any, irq_alarm}, 0, "R7 R10 irqs drop after clear");
    wr(3'd0, 32'h2);
    rd(3'd0, 0, "R7 clear bit 1");

    // R6 direct write onto alarm value does not latch
    wr(3'd3, 32'd203);
    rd(3'd0, 0, "R6 direct write no latch");

    // R9 periodic
    wr(3'd1, 32'h6);
    count_window(2 * P);
    check(cnt_a, 2, "R9 1 Hz pulses");
    check(cnt_b, 0, "R9 alarm B quiet");
    wr(3'd1, 32'h2);
    count_window(2 * P);
    check(cnt_a, 4, "R9 2 Hz pulses");
    check(cnt_any, 4, "R10 irq_any pulses");
    wr(3'd1, 32'h0);
    count_window(2 * P);
    check(cnt_a, 0, "R9 periodic disabled");

    // R5 wrap and restart
    wr(3'd3, 32'hFFFF_FFFF);
    ticks(P);
    rd(3'd3, 0, "R5 wrap to zero");

    repeat (4) @(negedge clk);
    check(exp_q.size(), 0, "reads drained");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule